// File: doc/BRIEF.md
# Instruction Boundary Mark Predecoder

This block sits in a variable-length instruction front end, between the buffer that holds fetched instruction bytes and the decoders that follow it. For every fetched window of bytes it produces one bit per byte. The bit is 1 where an instruction starts. These marks are kept in a small side array with one entry per instruction cache line. Each entry holds one bit per byte, which is one eighth of the line's data size, plus a short record of how far the last instruction of the window runs past its end. A valid flag goes with each entry.

When a window is fetched from a line whose marks are valid, the bytes and the stored marks go to decode one cycle later. When the marks are missing, the block runs a two-cycle predecode pass over the window, half a window per cycle. It writes the marks back as valid and then forwards the bytes. So a marked line is delivered two cycles sooner than an unmarked one. A line refill clears that line's valid flag. An instruction that runs past the end of a window carries its remaining length into the next window.

A reduced length table stands in for full length decoding:
- Three byte values act as one-byte prefixes that join the instruction after them.
- Every other byte is an opcode, whose low three bits give the number of bytes that follow it.

Both paths feed the same full decode downstream.

Top module: `boundary_marker`

## Requirements
- R1: After reset, dec_valid is 0, fetch_ready is 1 and every mark line is invalid, so the first fetch of any line takes the predecode path.
- R2: Marks follow the length table.
  - Byte i of a window is fetch_bytes[8i+7:8i] and is marked by dec_marks[i].
  - Bytes 0x66, 0xF2 and 0xF3 are prefixes: each is one byte and joins the instruction that follows it.
  - Any other byte b is an opcode followed by b[2:0] further bytes.
  - A mark is 1 exactly on the first byte of an instruction, which is its first prefix if it has any.
- R3: A fetch accepted on a line with valid marks raises dec_valid one cycle later, with the stored marks and the fetched bytes unchanged.
- R4: A fetch accepted on a line without valid marks raises dec_valid three cycles later. fetch_ready stays 0 in the two cycles in between. The marks are written back and the line becomes valid.
- R5: Predecode starts from the state left by the previous window: unfinished opcode bytes, or an open prefix run. fetch_restart=1 with the request makes it start at an instruction boundary at byte 0.
- R6: A marked fetch takes the stored marks as they are and sets the carried state to the value stored with the line. fetch_restart has no effect on it.
- R7: refill_en clears the valid flag of line refill_idx. A refill on the same cycle as a fetch of the same line makes that fetch take the predecode path.
- R8: A refill of the line under predecode, from acceptance to write-back, leaves the line invalid. The marks are still delivered.
- R9: fetch_valid while fetch_ready is 0 is ignored: no extra dec_valid and no change to the delivered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refill_en | input | 1 | Instruction line refilled this cycle |
| refill_idx | input | IDXW | Index of the refilled line |
| fetch_valid | input | 1 | Fetch window request |
| fetch_idx | input | IDXW | Line index of the window |
| fetch_restart | input | 1 | Window starts at an instruction boundary (branch target) |
| fetch_bytes | input | 8*WIN | Window bytes, byte 0 in the low bits |
| fetch_ready | output | 1 | Block can accept a window this cycle |
| dec_valid | output | 1 | One-cycle pulse: window delivered to decode |
| dec_bytes | output | 8*WIN | Delivered window bytes |
| dec_marks | output | WIN | Start-of-instruction bit per byte |

## Verification
The hardest case to reach from the ports is a refill that lands on the very line being predecoded, inside the two-cycle pass. The line must then stay unmarked even though its marks are delivered. The bench times a refill pulse to the first cycle after a predecode fetch is accepted, and also places one in the acceptance cycle. It then refetches the line and expects the three-cycle latency. It also produces prefix runs and long opcodes that span window edges, by biasing random bytes towards prefixes and by directed windows whose last instruction runs into the next window.

// File: rtl/boundary_marker.sv
module boundary_marker #(
  parameter int WIN   = 16,
  parameter int LINES = 16,
  localparam int IDXW = $clog2(LINES),
  localparam int HALF = WIN / 2,
  localparam int BW   = 8 * WIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            refill_en,
  input  logic [IDXW-1:0] refill_idx,
  input  logic            fetch_valid,
  input  logic [IDXW-1:0] fetch_idx,
  input  logic            fetch_restart,
  input  logic [BW-1:0]   fetch_bytes,
  output logic            fetch_ready,
  output logic            dec_valid,
  output logic [BW-1:0]   dec_bytes,
  output logic [WIN-1:0]  dec_marks
);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;

  st_t              st;
  logic [WIN-1:0]   mark_mem  [LINES];
  logic [3:0]       spill_mem [LINES];
  logic [LINES-1:0] line_ok;
  logic [3:0]       carry_q, mid_q;
  logic [BW-1:0]    buf_q;
  logic [IDXW-1:0]  idx_q;
  logic             kill_q;
  logic [HALF-1:0]  lo_marks_q;
  logic [BW-1:0]    out_bytes_q;
  logic [WIN-1:0]   out_marks_q;
  logic             out_v_q;

  // state: {prefix_open, bytes_left[2:0]}; result: {mark, next_state}
  function automatic logic [4:0] step(input logic [7:0] b, input logic [3:0] s);
    logic pre;
    pre = (b == 8'h66) || (b == 8'hF2) || (b == 8'hF3);
    if (s[2:0] != 3'd0) return {2'b00, s[2:0] - 3'd1};
    return {~s[3], pre, pre ? 3'd0 : b[2:0]};
  endfunction

  function automatic logic [HALF+3:0] scan_half(input logic [8*HALF-1:0] b, input logic [3:0] s0);
    logic [3:0]      s;
    logic [4:0]      r;
    logic [HALF-1:0] m;
    s = s0;
    m = '0;
    for (int i = 0; i < HALF; i++) begin
      r    = step(b[8*i +: 8], s);
      m[i] = r[4];
      s    = r[3:0];
    end
    return {s, m};
  endfunction

  logic [8*HALF-1:0] half_sel;
  logic [HALF+3:0]   scan_r;
  logic              lk_hit, accept, refill_here;

  assign half_sel    = (st == S_HI) ? buf_q[BW-1 -: 8*HALF] : buf_q[8*HALF-1:0];
  assign scan_r      = scan_half(half_sel, mid_q);
  assign lk_hit      = line_ok[fetch_idx] && !(refill_en && refill_idx == fetch_idx);
  assign accept      = fetch_valid && (st == S_IDLE);
  assign refill_here = refill_en && (refill_idx == idx_q);

  assign fetch_ready = (st == S_IDLE);
  assign dec_valid   = out_v_q;
  assign dec_bytes   = out_bytes_q;
  assign dec_marks   = out_marks_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      line_ok <= '0;
      carry_q <= '0;
      mid_q   <= '0;
      kill_q  <= 1'b0;
      out_v_q <= 1'b0;
    end else begin
      out_v_q <= 1'b0;
      if (refill_en) line_ok[refill_idx] <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (lk_hit) begin
            out_bytes_q <= fetch_bytes;
            out_marks_q <= mark_mem[fetch_idx];
            out_v_q     <= 1'b1;
            carry_q     <= spill_mem[fetch_idx];
          end else begin
            buf_q  <= fetch_bytes;
            idx_q  <= fetch_idx;
            mid_q  <= fetch_restart ? 4'd0 : carry_q;
            kill_q <= refill_en && (refill_idx == fetch_idx);
            st     <= S_LO;
          end
        end
        S_LO: begin
          lo_marks_q <= scan_r[HALF-1:0];
          mid_q      <= scan_r[HALF+3:HALF];
          if (refill_here) kill_q <= 1'b1;
          st         <= S_HI;
        end
        S_HI: begin
          out_bytes_q      <= buf_q;
          out_marks_q      <= {scan_r[HALF-1:0], lo_marks_q};
          out_v_q          <= 1'b1;
          carry_q          <= scan_r[HALF+3:HALF];
          mark_mem[idx_q]  <= {scan_r[HALF-1:0], lo_marks_q};
          spill_mem[idx_q] <= scan_r[HALF+3:HALF];
          if (!kill_q && !refill_here) line_ok[idx_q] <= 1'b1;
          st               <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/boundary_marker_chk.sv
module boundary_marker_chk #(
  parameter int LINES = 16,
  localparam int IDXW = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic             lk_hit,
  input logic             refill_en,
  input logic [IDXW-1:0]  refill_idx,
  input logic [LINES-1:0] line_ok,
  input logic             dec_valid
);

  assert_hit_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && lk_hit) |=> dec_valid);

  assert_miss_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !lk_hit) |=> (!fetch_ready && !dec_valid));

  assert_miss_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !lk_hit) |-> ##3 dec_valid);

  assert_refill_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_en |=> !line_ok[$past(refill_idx)]);

  assert_idle_after_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> fetch_ready);

endmodule

bind boundary_marker boundary_marker_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .lk_hit(lk_hit), .refill_en(refill_en), .refill_idx(refill_idx),
  .line_ok(line_ok), .dec_valid(dec_valid)
);

// File: tb/sim_boundary_marker.sv
module sim_boundary_marker;
  localparam int WIN = 16, LINES = 16, IDXW = 4, BW = 8 * WIN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic refill_en = 1'b0, fetch_valid = 1'b0, fetch_restart = 1'b0;
  logic [IDXW-1:0] refill_idx = '0, fetch_idx = '0;
  logic [BW-1:0] fetch_bytes = '0;
  logic fetch_ready, dec_valid;
  logic [BW-1:0] dec_bytes;
  logic [WIN-1:0] dec_marks;

  boundary_marker #(.WIN(WIN), .LINES(LINES)) u0 (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [WIN-1:0] m_marks [LINES];
  logic [3:0] m_spill [LINES];
  logic [LINES-1:0] m_ok = '0;
  logic [3:0] m_carry = '0;
  logic [WIN-1:0] last_marks;

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [WIN+3:0] ref_scan(input logic [BW-1:0] b, input logic [3:0] cin);
    int rem = int'(cin[2:0]);
    bit inpfx = cin[3];
    logic [WIN-1:0] m = '0;
    for (int i = 0; i < WIN; i++) begin
      logic [7:0] x = b[8*i +: 8];
      bit isp = (x == 8'h66) || (x == 8'hF2) || (x == 8'hF3);
      if (rem > 0) rem--;
      else if (inpfx) begin
        if (!isp) begin inpfx = 0; rem = int'(x[2:0]); end
      end else begin
        m[i] = 1'b1;
        if (isp) inpfx = 1; else rem = int'(x[2:0]);
      end
    end
    return {inpfx, 3'(rem), m};
  endfunction

  // mode: 0 plain, 1 refill same cycle, 2 refill one cycle later, 3 poke while busy
  task automatic do_fetch(input int idx, input logic [BW-1:0] b, input bit rs, input int mode);
    bit hit;
    int lat = 0;
    logic [WIN-1:0] em;
    logic [WIN+3:0] r;
    logic [BW-1:0] gb = '0;
    while (!fetch_ready) @(negedge clk);
    if (mode == 1) m_ok[idx] = 1'b0;
    hit = m_ok[idx];
    if (mode == 3 && hit) mode = 0;
    if (hit) begin
      em = m_marks[idx];
      m_carry = m_spill[idx];
      if (mode == 2) m_ok[idx] = 1'b0;
    end else begin
      r = ref_scan(b, rs ? 4'd0 : m_carry);
      em = r[WIN-1:0];
      m_marks[idx] = em;
      m_spill[idx] = r[WIN+3:WIN];
      m_carry = r[WIN+3:WIN];
      m_ok[idx] = (mode == 1 || mode == 2) ? 1'b0 : 1'b1;
    end
    fetch_valid = 1'b1; fetch_idx = IDXW'(idx); fetch_bytes = b; fetch_restart = rs;
    if (mode == 1) begin refill_en = 1'b1; refill_idx = IDXW'(idx); end
    @(negedge clk);
    fetch_valid = 1'b0; refill_en = 1'b0;
    if (mode == 2) begin refill_en = 1'b1; refill_idx = IDXW'(idx); end
    if (mode == 3) begin fetch_valid = 1'b1; fetch_idx = IDXW'(idx); fetch_bytes = ~b; end
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) begin @(negedge clk); refill_en = 1'b0; fetch_valid = 1'b0; end
      if (dec_valid && lat == 0) begin lat = k; last_marks = dec_marks; gb = dec_bytes; end
      if (lat != 0 && k >= 2) break;
    end
    check(hit ? "R3 latency" : "R4 latency", BW'(lat), hit ? BW'(1) : BW'(3));
    check("R2 marks", BW'(last_marks), BW'(em));
    check("R3 bytes", gb, b);
    if (mode == 3) begin
      @(negedge clk);
      check("R9 busy fetch ignored", BW'(dec_valid), BW'(0));
    end
  endtask

  task automatic do_refill(input int idx);
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    refill_en = 1'b1; refill_idx = IDXW'(idx);
    m_ok[idx] = 1'b0;
    @(negedge clk);
    refill_en = 1'b0;
  endtask

  function automatic logic [BW-1:0] rnd_win();
    logic [BW-1:0] w;
    for (int i = 0; i < WIN; i++) begin
      int s = $urandom % 8;
      if (s == 0) w[8*i +: 8] = 8'h66;
      else if (s == 1) w[8*i +: 8] = 8'hF3;
      else if (s == 2) w[8*i +: 8] = 8'hF2;
      else w[8*i +: 8] = 8'($urandom);
    end
    return w;
  endfunction

  initial begin
    logic [BW-1:0] w;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dec_valid after reset", BW'(dec_valid), BW'(0));
    check("R1 fetch_ready after reset", BW'(fetch_ready), BW'(1));

    // R2/R5: known window; last instruction spills one byte
    w = '0;
    w[7:0] = 8'h66; w[15:8] = 8'h01; w[31:24] = 8'h00; w[39:32] = 8'hF3;
    w[47:40] = 8'hF2; w[55:48] = 8'h07;
    for (int i = 7; i < 14; i++) w[8*i +: 8] = 8'h66;
    w[119:112] = 8'h02;
    do_fetch(5, w, 1'b1, 0);
    check("R2 literal marks", BW'(last_marks), BW'(16'h4019));
    do_fetch(6, '0, 1'b0, 0);
    check("R5 carry into next window", BW'(last_marks), BW'(16'hFFFE));
    // R6: hit restores the stored carry, restart ignored
    do_fetch(5, w, 1'b1, 0);
    check("R6 hit marks", BW'(last_marks), BW'(16'h4019));
    do_fetch(7, '0, 1'b0, 0);
    check("R6 carry from stored line", BW'(last_marks), BW'(16'hFFFE));
    // prefix run across the window edge
    w = '0; w[127:120] = 8'h66;
    do_fetch(8, w, 1'b1, 0);
    w = '0; w[7:0] = 8'hF2;
    do_fetch(9, w, 1'b0, 0);
    check("R5 prefix run continues", BW'(last_marks), BW'(16'hFFFC));
    // R5 restart clears carry
    w = '0; w[127:120] = 8'h07;
    do_fetch(10, w, 1'b1, 0);
    do_fetch(11, '0, 1'b1, 0);
    check("R5 restart", BW'(last_marks), BW'(16'hFFFF));
    // R7 same-cycle refill, R8 refill during pass, R9 poke while busy
    do_fetch(5, rnd_win(), 1'b0, 1);
    do_fetch(5, rnd_win(), 1'b0, 0);
    do_fetch(12, rnd_win(), 1'b0, 2);
    do_fetch(12, rnd_win(), 1'b0, 0);
    do_refill(12);
    do_fetch(12, rnd_win(), 1'b0, 3);

    for (int n = 0; n < 500; n++) begin
      int sel = $urandom % 10;
      int idx = $urandom % 6;
      if (sel == 0) do_refill(idx);
      else do_fetch(idx, rnd_win(), ($urandom % 8) == 0, (sel >= 7) ? sel - 6 : 0);
    end

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule